// File: doc/BRIEF.md
# Cache line coherence state controller

This block tracks the four-state coherence tag of every line in a write-back cache and decides how each processor access is handled. It sits between the processor request port and the memory-bus controller. For each access it chooses one of three outcomes: serve the access locally, post a plain bus read or write, or run an allocation (line fill). When the access completes it reports the line's new state and whether read data comes from the cache array. The memory-bus controller steers allocations through three inputs. The first marks the filled line Shared when memory is updated alongside a cache-to-cache transfer. The second sends the line directly to Modified, for read-for-ownership or for a fill that skips Exclusive. The third freezes a write miss so that it completes as a dummy bus cycle and is followed by an allocation.

Locked accesses are always posted to the bus and never change the tag. A locked read that hits a Modified line is answered from the array. A split-cycle output is raised while a locked access that spans two addresses is on the bus. Snoops from another cache can downgrade a line to Shared or invalidate it. A snoop that finds Modified data raises a write-back request.

The control engine has three named states. CTL_IDLE accepts a snoop or a request. CTL_POST holds a plain bus cycle. CTL_FILL holds an allocation. The transitions are:
- IDLE→IDLE when a snoop is served or an access completes locally.
- IDLE→POST for a locked access, a write to a Shared line or a write miss.
- IDLE→FILL for an unlocked read miss.
- POST→FILL when a write miss completes with the freeze input high.
- POST→IDLE when any other bus cycle completes.
- FILL→IDLE when the allocation completes.

Top module: `line_coh_ctrl`

## Requirements
- R1: After reset every line's state is Invalid. States are encoded I=00, S=01, E=10, M=11 on `cur_state` and `rsp_state`.
- R2: A locked read or write never changes the line's state, for hits in all four states and for misses.
- R3: Every locked access is posted to the bus, hit or miss. A locked read posts `bus_op`=01 and a locked write posts `bus_op`=10. The codes are 00 none, 01 read, 10 write, 11 allocation.
- R4: A locked read that hits a Modified line completes with `rsp_from_cache`=1. Every other locked read completes with `rsp_from_cache`=0, taking the data from the bus.
- R5: `split_cyc` is high only while a locked access with `req_split` set has its bus cycle in progress.
- R6: An unlocked read hit completes in its acceptance cycle, with no bus cycle, `rsp_from_cache`=1 and the state unchanged.
- R7: An unlocked write hit to an Exclusive or Modified line completes locally and leaves the line Modified. A write hit to a Shared line posts a bus write and the line stays Shared.
- R8: An unlocked read miss runs an allocation (`bus_op`=11). When `bus_done` arrives, the line becomes Modified if `mbc_to_m` is high. Otherwise it becomes Shared if `mbc_wt` is high, and Exclusive if neither is high.
- R9: An unlocked write miss posts a bus write. If `mbc_freeze` is high when that cycle completes, an allocation follows and the line takes the state given by the rules of R8. Otherwise the line stays Invalid.
- R10: A snoop with `snp_inv` set leaves the line Invalid. `snp_wb` is raised only if the prior state was Modified.
- R11: A snoop without `snp_inv` moves Modified and Exclusive lines to Shared and leaves Shared and Invalid lines as they are. `snp_wb` is raised only for Modified lines, and `snp_hit` whenever the prior state was not Invalid.
- R12: A snoop is served only while the engine is idle, and it takes priority over a request: `req_ready` stays low while `snp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Processor access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lock | input | 1 | Access is part of a locked sequence |
| req_split | input | 1 | Locked access spans two addresses |
| req_idx | input | IDX_W | Line index of the access; also selects `cur_state` |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| cur_state | output | 2 | Current state of line `req_idx` |
| rsp_valid | output | 1 | Access completes this cycle |
| rsp_state | output | 2 | Line state written on completion |
| rsp_from_cache | output | 1 | Read data comes from the cache array |
| bus_op | output | 2 | Bus cycle in progress: 00 none, 01 read, 10 write, 11 allocation |
| bus_done | input | 1 | Bus controller completes the current cycle |
| split_cyc | output | 1 | Locked split-address cycle on the bus |
| mbc_wt | input | 1 | Mark the allocated line Shared |
| mbc_to_m | input | 1 | Allocate the line directly to Modified |
| mbc_freeze | input | 1 | Freeze a write miss and follow it with an allocation |
| snp_valid | input | 1 | Snoop request |
| snp_inv | input | 1 | Snoop invalidates the line |
| snp_idx | input | IDX_W | Snooped line index |
| snp_ack | output | 1 | Snoop served this cycle |
| snp_hit | output | 1 | Snooped line was valid |
| snp_wb | output | 1 | Snooped line held Modified data |

## Verification
The bench builds the block with its default of eight lines. With eight lines, all four states can be held in separate lines at the same moment. This lets locked reads and writes hit Invalid, Shared, Exclusive and Modified lines in turn, without rebuilding state between the checks. There are also enough spare lines to cover the three freeze outcomes for write misses and snoops in every prior state. A driver computes each expected completion from the requirements and queues it. A monitor pops the queue whenever `rsp_valid` rises and compares the state and the data source.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    typedef enum logic [1:0] {
        MESI_I = 2'b00,
        MESI_S = 2'b01,
        MESI_E = 2'b10,
        MESI_M = 2'b11
    } mesi_e;

    typedef enum logic [1:0] {
        BOP_NONE  = 2'b00,
        BOP_READ  = 2'b01,
        BOP_WRITE = 2'b10,
        BOP_FILL  = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        CTL_IDLE = 2'b00,
        CTL_POST = 2'b01,
        CTL_FILL = 2'b10
    } ctl_e;

    typedef struct packed {
        logic    post;
        logic    fill;
        logic    wmiss;
        logic    from_cache;
        bus_op_e op;
        mesi_e   nxt;
    } acc_dec_t;

    function automatic mesi_e fill_state(input logic wt, input logic to_m);
        if (to_m)
            return MESI_M;
        else if (wt)
            return MESI_S;
        else
            return MESI_E;
    endfunction

endpackage

// File: rtl/lcc_access_decode.sv
module lcc_access_decode
    import lcc_pkg::*;
(
    input  logic     write,
    input  logic     lock,
    input  mesi_e    cur,
    output acc_dec_t dec
);
    always_comb begin
        dec            = '0;
        dec.op         = BOP_NONE;
        dec.nxt        = cur;
        if (lock) begin
            // locked cycles always go to the bus and keep the tag
            dec.post       = 1'b1;
            dec.op         = write ? BOP_WRITE : BOP_READ;
            dec.from_cache = !write && (cur == MESI_M);
        end else if (!write) begin
            unique case (cur)
                MESI_I: begin
                    dec.post = 1'b1;
                    dec.fill = 1'b1;
                    dec.op   = BOP_FILL;
                end
                MESI_S, MESI_E, MESI_M: dec.from_cache = 1'b1;
            endcase
        end else begin
            unique case (cur)
                MESI_I: begin
                    dec.post  = 1'b1;
                    dec.wmiss = 1'b1;
                    dec.op    = BOP_WRITE;
                end
                MESI_S: begin
                    dec.post = 1'b1;
                    dec.op   = BOP_WRITE;
                end
                MESI_E, MESI_M: dec.nxt = MESI_M;
            endcase
        end
    end
endmodule

// File: rtl/lcc_snoop_decode.sv
module lcc_snoop_decode
    import lcc_pkg::*;
(
    input  logic  inv,
    input  mesi_e cur,
    output logic  hit,
    output logic  wb,
    output mesi_e nxt
);
    always_comb begin
        hit = (cur != MESI_I);
        wb  = (cur == MESI_M);
        if (inv) begin
            nxt = MESI_I;
        end else begin
            unique case (cur)
                MESI_I:         nxt = MESI_I;
                MESI_S:         nxt = MESI_S;
                MESI_E, MESI_M: nxt = MESI_S;
            endcase
        end
    end
endmodule

// File: rtl/lcc_state_array.sv
module lcc_state_array
    import lcc_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  mesi_e            wdata,
    input  logic [IDX_W-1:0] ridx_a,
    output mesi_e            rdata_a,
    input  logic [IDX_W-1:0] ridx_b,
    output mesi_e            rdata_b
);
    mesi_e line_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                line_q[g] <= MESI_I;
            else if (we && (widx == IDX_W'(g)))
                line_q[g] <= wdata;
        end
    end

    assign rdata_a = line_q[ridx_a];
    assign rdata_b = line_q[ridx_b];
endmodule

// File: rtl/line_coh_ctrl.sv
module line_coh_ctrl
    import lcc_pkg::*;
#(
    parameter int LINES = 8,
    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_lock,
    input  logic             req_split,
    input  logic [IDX_W-1:0] req_idx,
    output logic             req_ready,
    output logic [1:0]       cur_state,
    output logic             rsp_valid,
    output logic [1:0]       rsp_state,
    output logic             rsp_from_cache,
    output logic [1:0]       bus_op,
    input  logic             bus_done,
    output logic             split_cyc,
    input  logic             mbc_wt,
    input  logic             mbc_to_m,
    input  logic             mbc_freeze,
    input  logic             snp_valid,
    input  logic             snp_inv,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_ack,
    output logic             snp_hit,
    output logic             snp_wb
);
    ctl_e             ctl_q, ctl_d;
    logic [IDX_W-1:0] idx_q;
    logic             lock_q, split_q, wmiss_q, fc_q;
    bus_op_e          op_q;
    mesi_e            nxt_q;

    mesi_e            st_a, st_b, snp_nxt, wdata;
    logic             we, sn_hit, sn_wb, accept;
    logic [IDX_W-1:0] widx;
    acc_dec_t         dec;

    lcc_state_array #(.LINES(LINES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .widx    (widx),
        .wdata   (wdata),
        .ridx_a  (req_idx),
        .rdata_a (st_a),
        .ridx_b  (snp_idx),
        .rdata_b (st_b)
    );

    lcc_access_decode u_acc (
        .write (req_write),
        .lock  (req_lock),
        .cur   (st_a),
        .dec   (dec)
    );

    lcc_snoop_decode u_snp (
        .inv (snp_inv),
        .cur (st_b),
        .hit (sn_hit),
        .wb  (sn_wb),
        .nxt (snp_nxt)
    );

    assign accept = (ctl_q == CTL_IDLE) && !snp_valid && req_valid;

    // state register and captured access context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q   <= CTL_IDLE;
            idx_q   <= '0;
            lock_q  <= 1'b0;
            split_q <= 1'b0;
            wmiss_q <= 1'b0;
            fc_q    <= 1'b0;
            op_q    <= BOP_NONE;
            nxt_q   <= MESI_I;
        end else begin
            ctl_q <= ctl_d;
            if (accept) begin
                idx_q   <= req_idx;
                lock_q  <= req_lock;
                split_q <= req_split;
                wmiss_q <= dec.wmiss;
                fc_q    <= dec.from_cache;
                op_q    <= dec.op;
                nxt_q   <= dec.nxt;
            end
        end
    end

    // next control state and all outputs
    always_comb begin
        ctl_d          = ctl_q;
        we             = 1'b0;
        widx           = idx_q;
        wdata          = nxt_q;
        req_ready      = 1'b0;
        rsp_valid      = 1'b0;
        rsp_state      = nxt_q;
        rsp_from_cache = 1'b0;
        bus_op         = BOP_NONE;
        snp_ack        = 1'b0;
        unique case (ctl_q)
            CTL_IDLE: begin
                req_ready = !snp_valid;
                if (snp_valid) begin
                    snp_ack = 1'b1;
                    we      = 1'b1;
                    widx    = snp_idx;
                    wdata   = snp_nxt;
                end else if (req_valid) begin
                    widx = req_idx;
                    if (!dec.post) begin
                        we             = 1'b1;
                        wdata          = dec.nxt;
                        rsp_valid      = 1'b1;
                        rsp_state      = dec.nxt;
                        rsp_from_cache = dec.from_cache;
                    end else begin
                        ctl_d = dec.fill ? CTL_FILL : CTL_POST;
                    end
                end
            end
            CTL_POST: begin
                bus_op = op_q;
                if (bus_done) begin
                    if (wmiss_q && mbc_freeze) begin
                        ctl_d = CTL_FILL;
                    end else begin
                        we             = 1'b1;
                        rsp_valid      = 1'b1;
                        rsp_from_cache = fc_q;
                        ctl_d          = CTL_IDLE;
                    end
                end
            end
            CTL_FILL: begin
                bus_op = BOP_FILL;
                if (bus_done) begin
                    we        = 1'b1;
                    wdata     = fill_state(mbc_wt, mbc_to_m);
                    rsp_valid = 1'b1;
                    rsp_state = fill_state(mbc_wt, mbc_to_m);
                    ctl_d     = CTL_IDLE;
                end
            end
            default: ctl_d = CTL_IDLE;
        endcase
    end

    assign split_cyc = (ctl_q == CTL_POST) && lock_q && split_q;
    assign cur_state = st_a;
    assign snp_hit   = snp_ack && sn_hit;
    assign snp_wb    = snp_ack && sn_wb;
endmodule

// File: rtl/lcc_checker.sv
module lcc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic       req_lock,
    input logic       req_split,
    input logic [1:0] cur_state,
    input logic       rsp_valid,
    input logic [1:0] rsp_state,
    input logic       rsp_from_cache,
    input logic [1:0] bus_op,
    input logic       bus_done,
    input logic       split_cyc,
    input logic       mbc_to_m,
    input logic       snp_valid
);
    logic       acc;
    logic       c_lock, c_split;
    logic [1:0] c_prior;

    assign acc = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_lock  <= 1'b0;
            c_split <= 1'b0;
            c_prior <= 2'b00;
        end else if (acc) begin
            c_lock  <= req_lock;
            c_split <= req_split;
            c_prior <= cur_state;
        end
    end

    a_r2_locked_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !acc && c_lock |-> rsp_state == c_prior);

    a_r3_locked_posted: assert property (@(posedge clk) disable iff (!rst_n)
        acc && req_lock |=> (bus_op == 2'b01) || (bus_op == 2'b10));

    a_r4_fill_data_from_bus: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (bus_op == 2'b11) |-> !rsp_from_cache);

    a_r5_split_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
        split_cyc |-> c_lock && c_split);

    a_r6_read_hit_local: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !req_lock && !req_write && (cur_state != 2'b00)
        |-> rsp_valid && rsp_from_cache && (rsp_state == cur_state));

    a_r7_excl_write_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !req_lock && req_write && (cur_state == 2'b10)
        |-> rsp_valid && (rsp_state == 2'b11));

    a_r8_fill_direct_m: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_op == 2'b11) && bus_done && mbc_to_m |-> rsp_valid && (rsp_state == 2'b11));

    a_r12_snoop_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !req_ready);
endmodule

bind line_coh_ctrl lcc_checker u_lcc_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_write      (req_write),
    .req_lock       (req_lock),
    .req_split      (req_split),
    .cur_state      (cur_state),
    .rsp_valid      (rsp_valid),
    .rsp_state      (rsp_state),
    .rsp_from_cache (rsp_from_cache),
    .bus_op         (bus_op),
    .bus_done       (bus_done),
    .split_cyc      (split_cyc),
    .mbc_to_m       (mbc_to_m),
    .snp_valid      (snp_valid)
);

// File: tb/line_coh_ctrl_bench.sv
`timescale 1ns/1ps
module line_coh_ctrl_bench;
    localparam int LINES = 8;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0, req_write = 1'b0, req_lock = 1'b0, req_split = 1'b0;
    logic [IDX_W-1:0] req_idx = '0;
    logic             req_ready;
    logic [1:0]       cur_state;
    logic             rsp_valid;
    logic [1:0]       rsp_state;
    logic             rsp_from_cache;
    logic [1:0]       bus_op;
    logic             bus_done = 1'b0;
    logic             split_cyc;
    logic             mbc_wt = 1'b0, mbc_to_m = 1'b0, mbc_freeze = 1'b0;
    logic             snp_valid = 1'b0, snp_inv = 1'b0;
    logic [IDX_W-1:0] snp_idx = '0;
    logic             snp_ack, snp_hit, snp_wb;

    line_coh_ctrl #(.LINES(LINES)) u_line_coh_ctrl (.*);

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        logic [1:0] st;
        logic       fc;
        string      tag;
    } exp_t;

    exp_t       exp_q [$];
    logic [1:0] ref_st [LINES];
    int         checks = 0;
    int         fails = 0;
    bit         finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [1:0] fst(input bit wt, input bit tom);
        return tom ? 2'b11 : (wt ? 2'b01 : 2'b10);
    endfunction

    // monitor: compare completions against the scoreboard queue
    always begin
        @(negedge clk);
        #2;
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6", "unexpected completion", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_state == e.st, e.tag, "rsp_state", rsp_state, e.st);
                chk(rsp_from_cache == e.fc, e.tag, "rsp_from_cache", rsp_from_cache, e.fc);
            end
        end
    end

    task automatic do_access(input int idx, input bit wr, input bit lk, input bit sp,
                             input bit frz, input bit wt, input bit tom, input string tag);
        logic [1:0] prior, fin, first;
        bit         fc, two;
        string      optag;
        prior = ref_st[idx];
        fc    = 1'b0;
        two   = 1'b0;
        if (lk) begin
            first = wr ? 2'b10 : 2'b01;
            fin   = prior;
            fc    = !wr && (prior == 2'b11);
        end else if (!wr) begin
            if (prior != 2'b00) begin
                first = 2'b00; fin = prior; fc = 1'b1;
            end else begin
                first = 2'b11; fin = fst(wt, tom);
            end
        end else if (prior == 2'b00) begin
            first = 2'b10; two = frz;
            fin   = frz ? fst(wt, tom) : 2'b00;
        end else if (prior == 2'b01) begin
            first = 2'b10; fin = 2'b01;
        end else begin
            first = 2'b00; fin = 2'b11;
        end
        optag = lk ? "R3" : tag;
        exp_q.push_back('{fin, fc, tag});

        @(negedge clk);
        req_idx = IDX_W'(idx); req_write = wr; req_lock = lk; req_split = sp;
        mbc_freeze = frz; mbc_wt = wt; mbc_to_m = tom;
        req_valid = 1'b1;
        #2;
        chk(req_ready == 1'b1, tag, "req_ready at request", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        #2;
        if (first == 2'b00) begin
            chk(req_ready && (bus_op == 2'b00), tag, "no bus cycle", bus_op, 0);
        end else begin
            chk(bus_op == first, optag, "bus_op", bus_op, first);
            chk(split_cyc == (lk && sp), "R5", "split_cyc", split_cyc, lk && sp);
            @(negedge clk); bus_done = 1'b1;
            @(negedge clk); bus_done = 1'b0;
            if (two) begin
                #2;
                chk(bus_op == 2'b11, "R9", "allocation after freeze", bus_op, 3);
                @(negedge clk); bus_done = 1'b1;
                @(negedge clk); bus_done = 1'b0;
            end
        end
        ref_st[idx] = fin;
        #3;
        req_idx = IDX_W'(idx);
        #1;
        chk(cur_state == fin, lk ? "R2" : tag, "line state after access", cur_state, fin);
    endtask

    task automatic do_snoop(input int idx, input bit inv, input string tag);
        logic [1:0] prior, fin;
        prior = ref_st[idx];
        @(negedge clk);
        snp_idx = IDX_W'(idx); snp_inv = inv; snp_valid = 1'b1;
        req_valid = 1'b1; req_idx = IDX_W'(idx);
        req_write = 1'b0; req_lock = 1'b0; req_split = 1'b0;
        #2;
        chk(snp_ack == 1'b1, tag, "snp_ack", snp_ack, 1);
        chk(snp_hit == (prior != 2'b00), tag, "snp_hit", snp_hit, prior != 2'b00);
        chk(snp_wb == (prior == 2'b11), tag, "snp_wb", snp_wb, prior == 2'b11);
        chk(req_ready == 1'b0, "R12", "req_ready during snoop", req_ready, 0);
        chk(rsp_valid == 1'b0, "R12", "no completion during snoop", rsp_valid, 0);
        @(negedge clk);
        snp_valid = 1'b0; req_valid = 1'b0;
        if (inv)
            fin = 2'b00;
        else
            fin = (prior == 2'b11 || prior == 2'b10) ? 2'b01 : prior;
        ref_st[idx] = fin;
        #3;
        req_idx = IDX_W'(idx);
        #1;
        chk(cur_state == fin, tag, "line state after snoop", cur_state, fin);
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) ref_st[i] = 2'b00;
        repeat (3) @(negedge clk);
        for (int i = 0; i < LINES; i++) begin
            req_idx = IDX_W'(i);
            #1;
            chk(cur_state == 2'b00, "R1", "reset state", cur_state, 0);
        end
        rst_n = 1'b1;
        chk(rsp_valid == 1'b0 && bus_op == 2'b00, "R1", "idle after reset", bus_op, 0);

        // allocations: plain, shared marking, direct to modified, both
        do_access(0, 0, 0, 0, 0, 0, 0, "R8");
        do_access(1, 0, 0, 0, 0, 1, 0, "R8");
        do_access(2, 0, 0, 0, 0, 0, 1, "R8");
        do_access(3, 0, 0, 0, 0, 1, 1, "R8");
        do_access(0, 0, 0, 0, 0, 0, 0, "R6");
        // locked reads in I, S, E, M
        do_access(4, 0, 1, 0, 0, 0, 0, "R4");
        do_access(1, 0, 1, 0, 0, 0, 0, "R4");
        do_access(0, 0, 1, 0, 0, 0, 0, "R4");
        do_access(2, 0, 1, 1, 0, 0, 0, "R4");
        // locked writes in I, S, E, M
        do_access(4, 1, 1, 0, 0, 1, 1, "R2");
        do_access(1, 1, 1, 1, 0, 0, 0, "R2");
        do_access(0, 1, 1, 0, 1, 0, 1, "R2");
        do_access(2, 1, 1, 0, 0, 0, 0, "R2");
        do_access(3, 0, 1, 1, 0, 0, 0, "R5");
        do_access(3, 0, 0, 1, 0, 0, 0, "R5");
        // write hits
        do_access(0, 1, 0, 0, 0, 0, 0, "R7");
        do_access(1, 1, 0, 0, 0, 0, 0, "R7");
        do_access(2, 1, 0, 0, 0, 0, 0, "R7");
        // write misses: no freeze, freeze with each allocation control
        do_access(5, 1, 0, 0, 0, 0, 1, "R9");
        do_access(6, 1, 0, 0, 1, 0, 1, "R9");
        do_access(7, 1, 0, 0, 1, 0, 0, "R9");
        do_access(4, 1, 0, 0, 1, 1, 0, "R9");
        // snoops
        do_snoop(2, 0, "R11");
        do_snoop(7, 0, "R11");
        do_snoop(1, 0, "R11");
        do_snoop(5, 0, "R11");
        do_snoop(6, 1, "R10");
        do_snoop(4, 1, "R10");
        do_snoop(3, 1, "R10");
        do_snoop(5, 1, "R10");
        do_access(2, 0, 0, 0, 0, 0, 0, "R6");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R6", "pending completions", exp_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule